// File: doc/BRIEF.md
# Indexed Extended Register Port

This block is a small bank of 8-bit extension registers that the host reaches through two adjacent I/O addresses. The lower address selects a register, and the upper address, one above it, moves data. A 16-bit write to the lower address carries the register number in its low byte and the new value in its high byte, so a full update takes a single bus cycle. A read takes two cycles: the host writes the register number as a byte to the lower address, then reads a byte from the upper address.

A register number latched by a byte write serves one data access only and is then dropped. Writing data with two byte accesses, the number first and the value second, is not permitted. The block refuses such a write and records it in a sticky error flag. A read that has no valid register number also sets the flag. Every register value is driven in parallel onto a flat output vector, so the rest of the chip can use the settings directly.

Top module: `ext_idx_port`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o`, `err_o` is 0 and `rvalid_o` is 0.
- R2: A 16-bit write (`req_word_i`=1) to `BASE_ADDR` with a register number from 0xA0 to 0xBF in `req_wdata_i[7:0]` stores `req_wdata_i[15:8]`. The new value is visible from the next cycle in byte k of `regs_o` (bits 8k+7:8k), where k is the register number minus 0xA0.
- R3: A byte write to `BASE_ADDR` followed by a byte read of `BASE_ADDR+1` returns the selected register on `rdata_o`. `rvalid_o` is 1 in the cycle after each byte read of `BASE_ADDR+1` and 0 otherwise.
- R4: A latched register number is invalidated by any data-port access and by any 16-bit write to `BASE_ADDR`. A later read without a fresh byte write of a number returns 0xFF.
- R5: A byte write to `BASE_ADDR+1` changes no register and sets `err_o`.
- R6: A byte read of `BASE_ADDR+1` while no register number is valid returns 0xFF and sets `err_o`.
- R7: `err_o` stays 1 until a cycle with `err_clr_i`=1 and no new error. A new error in the same cycle as `err_clr_i` leaves `err_o` at 1.
- R8: A 16-bit write whose register number lies outside 0xA0 to 0xBF changes no register and raises no error.
- R9: A latched register number outside 0xA0 to 0xBF reads back 0xFF without raising an error.
- R10: An access to any address other than `BASE_ADDR` or `BASE_ADDR+1` changes no register, produces no `rvalid_o` and leaves a latched register number valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus access in this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr_i | input | 16 | I/O address |
| req_wdata_i | input | 16 | Write data; a byte access uses bits 7:0 |
| err_clr_i | input | 1 | Clears the sticky error flag |
| rvalid_o | output | 1 | Read data valid, one cycle after a data-port read |
| rdata_o | output | 8 | Read data |
| err_o | output | 1 | Sticky access-error flag |
| regs_o | output | 256 | All registers, one byte per number from 0xA0 upward |

## Verification
The assertions treat each cycle as carrying at most one access, fully described by the request inputs in that cycle. They also assume `err_clr_i` is a plain level sampled at the clock edge. The bench drives each access for exactly one cycle, changing inputs only on the falling edge, and returns every request input to idle between accesses. Reads of the data port always follow either a fresh byte write of a register number or a deliberate violation, so every error the assertions expect comes from a known stimulus.

// File: rtl/ext_port_pkg.sv
package ext_port_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_WORD_WR,
    OP_IDX_WR,
    OP_DATA_WR,
    OP_DATA_RD
  } port_op_e;
endpackage

// File: rtl/ext_port_decode.sv
module ext_port_decode
  import ext_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01CE
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output port_op_e          op_o
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      if (addr_i == BASE_ADDR && write_i) begin
        op_o = word_i ? OP_WORD_WR : OP_IDX_WR;
      end else if (addr_i == DATA_ADDR && !word_i) begin
        op_o = write_i ? OP_DATA_WR : OP_DATA_RD;
      end
    end
  end
endmodule

// File: rtl/ext_port_index.sv
module ext_port_index
  import ext_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  port_op_e   op_i,
  input  logic [7:0] idx_i,
  input  logic       err_clr_i,
  output logic [7:0] idx_o,
  output logic       idx_vld_o,
  output logic       err_o
);
  logic err_ev;

  // paired-byte write, or a read with nothing latched
  assign err_ev = (op_i == OP_DATA_WR) || (op_i == OP_DATA_RD && !idx_vld_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= 8'h00;
      idx_vld_o <= 1'b0;
    end else begin
      unique case (op_i)
        OP_IDX_WR: begin
          idx_o     <= idx_i;
          idx_vld_o <= 1'b1;
        end
        OP_WORD_WR, OP_DATA_WR, OP_DATA_RD: idx_vld_o <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (err_ev)    err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end
endmodule

// File: rtl/ext_port_regfile.sv
module ext_port_regfile #(
  parameter int unsigned NUM_REGS  = 32,
  parameter logic [7:0]  FIRST_IDX = 8'hA0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [7:0]            rd_idx_i,
  output logic                  rd_hit_o,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0]  LO_IDX   = {1'b0, FIRST_IDX};
  localparam logic [8:0]  HI_IDX   = LO_IDX + 9'(NUM_REGS) - 9'd1;

  logic [7:0] regs_q [NUM_REGS];
  logic       wr_hit;
  logic [7:0] wr_off, rd_off;

  assign wr_hit = ({1'b0, wr_idx_i} >= LO_IDX) && ({1'b0, wr_idx_i} <= HI_IDX);
  assign rd_hit_o = ({1'b0, rd_idx_i} >= LO_IDX) && ({1'b0, rd_idx_i} <= HI_IDX);
  assign wr_off = wr_idx_i - FIRST_IDX;
  assign rd_off = rd_idx_i - FIRST_IDX;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[k] <= 8'h00;
      else if (wr_en_i && wr_hit && wr_off[SEL_W-1:0] == SEL_W'(k))
        regs_q[k] <= wr_data_i;
    end
    assign regs_o[k*8 +: 8] = regs_q[k];
  end

  assign rd_data_o = rd_hit_o ? regs_q[rd_off[SEL_W-1:0]] : 8'hFF;
endmodule

// File: rtl/ext_idx_port.sv
module ext_idx_port
  import ext_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01CE,
  parameter int unsigned NUM_REGS  = 32,
  parameter logic [7:0]  FIRST_IDX = 8'hA0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic                  req_word_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [15:0]           req_wdata_i,
  input  logic                  err_clr_i,
  output logic                  rvalid_o,
  output logic [7:0]            rdata_o,
  output logic                  err_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  port_op_e   op;
  logic [7:0] idx_q;
  logic       idx_vld;
  logic       rd_hit;
  logic [7:0] rd_data;

  ext_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .word_i  (req_word_i),
    .addr_i  (req_addr_i),
    .op_o    (op)
  );

  ext_port_index u_index (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .idx_i     (req_wdata_i[7:0]),
    .err_clr_i (err_clr_i),
    .idx_o     (idx_q),
    .idx_vld_o (idx_vld),
    .err_o     (err_o)
  );

  ext_port_regfile #(.NUM_REGS(NUM_REGS), .FIRST_IDX(FIRST_IDX)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (op == OP_WORD_WR),
    .wr_idx_i  (req_wdata_i[7:0]),
    .wr_data_i (req_wdata_i[15:8]),
    .rd_idx_i  (idx_q),
    .rd_hit_o  (rd_hit),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 8'h00;
    end else begin
      rvalid_o <= (op == OP_DATA_RD);
      if (op == OP_DATA_RD)
        rdata_o <= (idx_vld && rd_hit) ? rd_data : 8'hFF;
    end
  end
endmodule

// File: rtl/ext_idx_port_chk.sv
module ext_idx_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01CE,
  parameter int unsigned NUM_REGS  = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_write_i,
  input logic                  req_word_i,
  input logic [ADDR_W-1:0]     req_addr_i,
  input logic                  err_clr_i,
  input logic                  rvalid_o,
  input logic                  err_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  logic dwr, drd, wwr;
  assign dwr = req_valid_i && req_write_i && !req_word_i && req_addr_i == BASE_ADDR + 1'b1;
  assign drd = req_valid_i && !req_write_i && !req_word_i && req_addr_i == BASE_ADDR + 1'b1;
  assign wwr = req_valid_i && req_write_i && req_word_i && req_addr_i == BASE_ADDR;

  // R5
  data_wr_no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr |=> $stable(regs_o));
  // R5
  data_wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr |=> err_o);
  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  // R7
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !dwr && !drd) |=> !err_o);
  // R3
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drd |=> rvalid_o);
  // R3
  rvalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drd |=> !rvalid_o);
  // R10
  regs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wwr |=> $stable(regs_o));
endmodule

bind ext_idx_port ext_idx_port_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_word_i(req_word_i), .req_addr_i(req_addr_i),
  .err_clr_i(err_clr_i), .rvalid_o(rvalid_o), .err_o(err_o), .regs_o(regs_o)
);

// File: tb/ext_idx_port_bench.sv
module ext_idx_port_bench;
  localparam logic [15:0] BASE = 16'h01CE;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, err_clr = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic rvalid, err;
  logic [7:0] rdata;
  logic [255:0] regs, exp_regs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_idx_port u_ext_idx_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_word_i(req_word), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .err_clr_i(err_clr), .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err), .regs_o(regs)
  );

  // kind: 0 word wr base, 1 byte wr base, 2 byte wr data port, 3 byte rd data port,
  //       4 byte wr unrelated address, 5 idle with err clear
  // entry: {kind[2:0], wdata[15:0], exp_rvalid, exp_rdata[7:0], exp_err, req[3:0]}
  localparam logic [32:0] VEC [NV] = '{
    {3'd0, 16'h3CA5, 1'b0, 8'h00, 1'b0, 4'd2},  // R2
    {3'd1, 16'h00A5, 1'b0, 8'h00, 1'b0, 4'd3},
    {3'd3, 16'h0000, 1'b1, 8'h3C, 1'b0, 4'd3},  // R3 read back
    {3'd3, 16'h0000, 1'b1, 8'hFF, 1'b1, 4'd4},  // R4 index used up
    {3'd5, 16'h0000, 1'b0, 8'h00, 1'b0, 4'd7},  // R7 clear
    {3'd0, 16'h81BF, 1'b0, 8'h00, 1'b0, 4'd2},
    {3'd1, 16'h00BF, 1'b0, 8'h00, 1'b0, 4'd3},
    {3'd4, 16'h00A0, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 foreign address
    {3'd3, 16'h0000, 1'b1, 8'h81, 1'b0, 4'd10}, // R10 index kept
    {3'd1, 16'h00A0, 1'b0, 8'h00, 1'b0, 4'd5},
    {3'd2, 16'h0077, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 paired-byte write
    {3'd3, 16'h0000, 1'b1, 8'hFF, 1'b1, 4'd6},  // R6 nothing latched
    {3'd5, 16'h0000, 1'b0, 8'h00, 1'b0, 4'd7},
    {3'd0, 16'h5510, 1'b0, 8'h00, 1'b0, 4'd8},  // R8 out of range
    {3'd1, 16'h0010, 1'b0, 8'h00, 1'b0, 4'd9},
    {3'd3, 16'h0000, 1'b1, 8'hFF, 1'b0, 4'd9},  // R9
    {3'd1, 16'h00A0, 1'b0, 8'h00, 1'b0, 4'd4},
    {3'd0, 16'h22A1, 1'b0, 8'h00, 1'b0, 4'd4},
    {3'd3, 16'h0000, 1'b1, 8'hFF, 1'b1, 4'd4},  // R4 word write drops index
    {3'd5, 16'h0000, 1'b0, 8'h00, 1'b0, 4'd7},
    {3'd1, 16'h00A0, 1'b0, 8'h00, 1'b0, 4'd5},
    {3'd3, 16'h0000, 1'b1, 8'h00, 1'b0, 4'd5}   // R5 reg untouched
  };

  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one access at a falling edge, hold one cycle, then idle
  task automatic acc(input logic [2:0] kind, input logic [15:0] wd, input logic clr);
    req_valid = (kind != 3'd5);
    req_write = (kind != 3'd3);
    req_word  = (kind == 3'd0);
    req_addr  = (kind == 3'd0 || kind == 3'd1) ? BASE :
                (kind == 3'd4) ? BASE + 16'd2 : BASE + 16'd1;
    req_wdata = wd;
    err_clr   = clr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; err_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    exp_regs = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "regs", regs, '0);
    chk("R1", "err", {255'd0, err}, '0);
    chk("R1", "rvalid", {255'd0, rvalid}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] kind;
      logic [15:0] wd;
      string rq;
      kind = VEC[i][32:30];
      wd   = VEC[i][29:14];
      rq   = $sformatf("R%0d", VEC[i][3:0]);
      acc(kind, wd, kind == 3'd5);
      if (kind == 3'd0 && wd[7:0] >= 8'hA0 && wd[7:0] <= 8'hBF)
        exp_regs[(wd[7:0] - 8'hA0) * 8 +: 8] = wd[15:8];
      chk(rq, $sformatf("vec %0d rvalid", i), {255'd0, rvalid}, {255'd0, VEC[i][13]});
      chk(rq, $sformatf("vec %0d err", i), {255'd0, err}, {255'd0, VEC[i][4]});
      if (VEC[i][13])
        chk(rq, $sformatf("vec %0d rdata", i), {248'd0, rdata}, {248'd0, VEC[i][12:5]});
      chk(rq, $sformatf("vec %0d regs", i), regs, exp_regs);
    end

    // R2 byte placement in the flat vector
    chk("R2", "reg A5 byte", {248'd0, regs[5*8 +: 8]}, {248'd0, 8'h3C});
    chk("R2", "reg BF byte", {248'd0, regs[31*8 +: 8]}, {248'd0, 8'h81});

    // R7 error and clear in the same cycle: set wins
    acc(3'd2, 16'h0011, 1'b1);
    chk("R7", "set beats clear", {255'd0, err}, {255'd0, 1'b1});
    chk("R5", "no update", regs, exp_regs);
    acc(3'd5, 16'h0000, 1'b0);
    chk("R7", "sticky idle", {255'd0, err}, {255'd0, 1'b1});
    acc(3'd5, 16'h0000, 1'b1);
    chk("R7", "cleared", {255'd0, err}, '0);

    // R1 reset mid-run returns everything to zero
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "regs after reset", regs, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    acc(3'd1, 16'h00A5, 1'b0);
    acc(3'd3, 16'h0000, 1'b0);
    chk("R1", "reg cleared by reset", {248'd0, rdata}, '0);

    finish_run();
  end
endmodule